// File: doc/BRIEF.md
# Host-to-Local Command/Data Mailbox

This block is a pair of one-byte mailboxes that a host fills over a decoded I/O bus and a local processor drains through a plain register read port. Each mailbox is reached at two host addresses. Writing through the lower address marks the byte as data. Writing through the upper address marks it as a command. The block records that choice in a per-channel command flag, next to the captured byte.

Each channel also keeps a full flag. A host write sets it, and a local read of that channel's byte clears it. The host can poll either channel's flags by reading that channel's command-alias address. Host writes that miss the decode window are dropped without side effects.

Top module: `host_mailbox`

## Requirements
- R1: A host write at address 0x0060 stores the write byte in channel 0 and clears channel 0's command flag. The byte then appears on `loc_rdata` while `loc_sel` is 0.
- R2: A host write at address 0x0064 stores the write byte in channel 0 and sets channel 0's command flag.
- R3: Host writes at 0x0062 and 0x0066 do the same for channel 1, with the command flag 0 and 1 respectively. The byte appears on `loc_rdata` while `loc_sel` is 1.
- R4: A host write decodes only when address bits 15:4 equal 0x006 and bits 3 and 0 are both 0. Any other write leaves every byte and every flag unchanged.
- R5: Every decoded host write sets the addressed channel's full flag (`ibf_flags[ch]`).
- R6: A `loc_rd` pulse clears the full flag of the channel named by `loc_sel` one cycle later. The other channel's flag is unaffected.
- R7: If a decoded host write and a local read hit the same channel in the same cycle, the full flag stays set and the new byte is stored.
- R8: While `host_rd` is high at 0x0064 or 0x0066, `host_rdata` holds that channel's status byte: bit 3 is the command flag, bit 1 is the full flag, and every other bit is 0. At every other time `host_rdata` is 0x00.
- R9: After a synchronous reset, all full flags and command flags are 0. The stored bytes are undefined until the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | 16 | Host I/O address |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Host read data (status byte or 0x00) |
| loc_sel | input | 1 | Local channel select |
| loc_rd | input | 1 | Local read strobe; clears the selected full flag |
| loc_rdata | output | 8 | Byte held by the selected channel |
| ibf_flags | output | 2 | Full flag per channel |
| cd_flags | output | 2 | Command flag per channel |

## Verification
The assertions treat each cycle in which `host_wr` is high as one complete host write. A strobe held high for several cycles is therefore taken as repeated writes. The stimulus always drives one-cycle strobes. The assertions also assume inputs are stable across the sampling edge, so the bench changes every input on the falling edge. The R4 stability check only holds when no local read is pending, so it is gated on `loc_rd` being low. The bench mixes stray addresses with aliased ones and with local reads of either channel, so that the gated and ungated cases both occur.

// File: rtl/mbx_pkg.sv
// Package: shared constants for the host mailbox.
// Assumes a 16-bit host address space and byte-wide mailboxes.
package mbx_pkg;
    localparam int MBX_ADDR_W   = 16;
    localparam int MBX_DATA_W   = 8;
    localparam int MBX_NUM_CH   = 2;
    localparam int MBX_CH_W     = $clog2(MBX_NUM_CH);
    localparam int MBX_HI_W     = MBX_ADDR_W - 4;
    localparam logic [MBX_HI_W-1:0] MBX_BASE_HI = 12'h006;
    // Status byte layout seen by the host
    localparam int STS_CMD_BIT  = 3;
    localparam int STS_FULL_BIT = 1;
    // Address bit carrying the command/data choice, and the channel index field
    localparam int CMD_ADDR_BIT = 2;
    localparam int CH_ADDR_LSB  = 1;
endpackage

// File: rtl/mbx_addr_dec.sv
// Module: mbx_addr_dec
// Decodes host I/O cycles into a one-hot per-channel write enable and a
// one-hot per-channel status-read select.
// Assumes: a window of 16 bytes starting at BASE_HI << 4, with bits 3 and 0 zero.
// The channel index sits at CH_ADDR_LSB and the command choice at CMD_ADDR_BIT.
module mbx_addr_dec
    import mbx_pkg::*;
#(
    parameter int ADDR_W = MBX_ADDR_W,
    parameter int NUM_CH = MBX_NUM_CH,
    parameter logic [ADDR_W-5:0] BASE_HI = MBX_BASE_HI
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic [NUM_CH-1:0] wr_sel,
    output logic [NUM_CH-1:0] sts_sel,
    output logic              cmd_bit
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic            win_hit;
    logic [CH_W-1:0] ch_idx;

    // Purpose: match the fixed window and pull out the channel and command bits.
    always_comb begin
        win_hit = (addr[ADDR_W-1:4] == BASE_HI) && !addr[3] && !addr[0];
        ch_idx  = addr[CH_ADDR_LSB +: CH_W];
        cmd_bit = addr[CMD_ADDR_BIT];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        // Purpose: raise the per-channel strobes for this channel index.
        always_comb begin
            wr_sel[g]  = wr && win_hit && (ch_idx == CH_W'(g));
            sts_sel[g] = rd && win_hit && cmd_bit && (ch_idx == CH_W'(g));
        end
    end
endmodule

// File: rtl/mbx_channel.sv
// Module: mbx_channel
// One mailbox slot: a byte that the host writes, the command flag taken from
// the write alias, and a full flag.
// Assumes: wr_en is high for one cycle per host write. rd_clr marks a local read.
// When both are high in one cycle, the write wins.
module mbx_channel #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              cmd_in,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_clr,
    output logic [DATA_W-1:0] data_q,
    output logic              cd_q,
    output logic              full_q
);
    // Purpose: capture the host byte; not reset, its content is undefined until written.
    always_ff @(posedge clk) begin
        if (wr_en) data_q <= wdata;
    end

    // Purpose: latch the command/data choice and track the full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd_q   <= 1'b0;
            full_q <= 1'b0;
        end else begin
            if (wr_en)       cd_q <= cmd_in;
            if (wr_en)       full_q <= 1'b1;
            else if (rd_clr) full_q <= 1'b0;
        end
    end

    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> data_q == $past(wdata));
    assert_cmd_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cd_q == $past(cmd_in));
    assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cd_q));
    assert_full_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> full_q);
    assert_full_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !wr_en) |=> !full_q);
    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && wr_en) |=> full_q && data_q == $past(wdata));
endmodule

// File: rtl/host_mailbox.sv
// Module: host_mailbox (top)
// A bank of host-to-local mailboxes behind a decoded I/O bus. It holds the
// address decoder, one slot per channel, and the read muxes for both sides.
// Assumes: a single clock domain, one-cycle host strobes, and DATA_W >= 4 so
// that the status bits fit.
module host_mailbox
    import mbx_pkg::*;
#(
    parameter int ADDR_W = MBX_ADDR_W,
    parameter int DATA_W = MBX_DATA_W,
    parameter int NUM_CH = MBX_NUM_CH,
    parameter logic [ADDR_W-5:0] BASE_HI = MBX_BASE_HI
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             host_addr,
    input  logic [DATA_W-1:0]             host_wdata,
    input  logic                          host_wr,
    input  logic                          host_rd,
    output logic [DATA_W-1:0]             host_rdata,
    input  logic [$clog2(NUM_CH)-1:0]     loc_sel,
    input  logic                          loc_rd,
    output logic [DATA_W-1:0]             loc_rdata,
    output logic [NUM_CH-1:0]             ibf_flags,
    output logic [NUM_CH-1:0]             cd_flags
);
    localparam int SEL_W = $clog2(NUM_CH);

    logic [NUM_CH-1:0] wr_sel;
    logic [NUM_CH-1:0] sts_sel;
    logic              cmd_bit;
    logic [DATA_W-1:0] slot_data [NUM_CH];

    mbx_addr_dec #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH),
        .BASE_HI(BASE_HI)
    ) u_dec (
        .addr   (host_addr),
        .wr     (host_wr),
        .rd     (host_rd),
        .wr_sel (wr_sel),
        .sts_sel(sts_sel),
        .cmd_bit(cmd_bit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic rd_here;
        // Purpose: route the local read strobe to the selected slot.
        always_comb rd_here = loc_rd && (loc_sel == SEL_W'(g));

        mbx_channel #(.DATA_W(DATA_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_sel[g]),
            .cmd_in(cmd_bit),
            .wdata (host_wdata),
            .rd_clr(rd_here),
            .data_q(slot_data[g]),
            .cd_q  (cd_flags[g]),
            .full_q(ibf_flags[g])
        );
    end

    // Purpose: local read port, showing the byte of the selected slot.
    always_comb loc_rdata = slot_data[loc_sel];

    // Purpose: host status read, returning the selected slot's flags or zero.
    always_comb begin
        host_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sts_sel[i]) begin
                host_rdata[STS_CMD_BIT]  = cd_flags[i];
                host_rdata[STS_FULL_BIT] = ibf_flags[i];
            end
        end
    end

    assert_reset_clear_R9: assert property (@(posedge clk)
        $rose(rst_n) |-> (ibf_flags == '0) && (cd_flags == '0));
    assert_stray_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !loc_rd &&
         ((host_addr[ADDR_W-1:4] != BASE_HI) || host_addr[3] || host_addr[0]))
        |=> $stable(ibf_flags) && $stable(cd_flags));
    assert_status_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr[CMD_ADDR_BIT] && (host_addr[ADDR_W-1:4] == BASE_HI)
         && !host_addr[3] && !host_addr[0])
        |-> host_rdata[STS_CMD_BIT] == cd_flags[host_addr[CH_ADDR_LSB +: SEL_W]]
            && host_rdata[STS_FULL_BIT] == ibf_flags[host_addr[CH_ADDR_LSB +: SEL_W]]);
    assert_idle_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |-> host_rdata == '0);
endmodule

// File: tb/host_mailbox_bench.sv
module host_mailbox_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic        loc_sel = 1'b0;
    logic        loc_rd = 1'b0;
    logic [7:0]  loc_rdata;
    logic [1:0]  ibf_flags;
    logic [1:0]  cd_flags;

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    logic [7:0] m_data [2];
    bit         m_valid [2];
    bit         m_cd [2];
    bit         m_full [2];

    always #10 clk = ~clk;

    host_mailbox u_host_mailbox (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .loc_sel(loc_sel), .loc_rd(loc_rd), .loc_rdata(loc_rdata),
        .ibf_flags(ibf_flags), .cd_flags(cd_flags)
    );

    function automatic bit decodes(input logic [15:0] a);
        return (a[15:4] == 12'h006) && !a[3] && !a[0];
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive, compare everything against the model, then advance it
    task automatic step(input string tag, input logic [15:0] a, input logic [7:0] d,
                        input bit w, input bit r, input bit ls, input bit lr);
        logic [7:0] exp_rd;
        host_addr = a; host_wdata = d; host_wr = w; host_rd = r;
        loc_sel = ls; loc_rd = lr;
        #1;
        exp_rd = 8'h00;
        if (r && decodes(a) && a[2]) begin
            exp_rd[3] = m_cd[a[1]];
            exp_rd[1] = m_full[a[1]];
        end
        chk({tag, " R8 host_rdata"}, host_rdata, exp_rd);
        chk({tag, " R5/R6 ibf_flags"}, {6'b0, ibf_flags}, {6'b0, m_full[1], m_full[0]});
        chk({tag, " R1/R2/R3 cd_flags"}, {6'b0, cd_flags}, {6'b0, m_cd[1], m_cd[0]});
        if (m_valid[ls]) chk({tag, " R1/R3 loc_rdata"}, loc_rdata, m_data[ls]);
        @(posedge clk);
        if (rst_n) begin
            if (lr) m_full[ls] = 1'b0;
            if (w && decodes(a)) begin
                m_data[a[1]]  = d;
                m_valid[a[1]] = 1'b1;
                m_cd[a[1]]    = a[2];
                m_full[a[1]]  = 1'b1;
            end
        end
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0; loc_rd = 1'b0;
    endtask

    function automatic logic [15:0] pick_addr();
        case ($urandom % 10)
            0: return 16'h0060;
            1: return 16'h0062;
            2: return 16'h0064;
            3: return 16'h0066;
            4: return 16'h0061;
            5: return 16'h0068;
            6: return 16'h0164;
            7: return 16'h006E;
            8: return 16'h8062;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_valid[i] = 0; m_cd[i] = 0; m_full[i] = 0; m_data[i] = '0;
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: flags clear after reset, status reads zero
        step("R9 rst", 16'h0064, 8'h00, 0, 1, 0, 0);
        step("R9 rst", 16'h0066, 8'h00, 0, 1, 1, 0);
        // R1: data alias for channel 0
        step("R1 wr", 16'h0060, 8'hA5, 1, 0, 0, 0);
        step("R1 chk", 16'h0064, 8'h00, 0, 1, 0, 0);
        // R2: command alias for channel 0
        step("R2 wr", 16'h0064, 8'h3C, 1, 0, 0, 0);
        step("R2 chk", 16'h0064, 8'h00, 0, 1, 0, 0);
        // R3: channel 1 via both aliases
        step("R3 wr", 16'h0066, 8'h81, 1, 0, 1, 0);
        step("R3 wr", 16'h0062, 8'h7E, 1, 0, 1, 0);
        step("R3 chk", 16'h0066, 8'h00, 0, 1, 1, 0);
        // R4: writes outside the window leave state untouched
        step("R4 stray", 16'h0061, 8'hFF, 1, 0, 0, 0);
        step("R4 stray", 16'h0068, 8'hEE, 1, 0, 1, 0);
        step("R4 stray", 16'h0164, 8'hDD, 1, 0, 0, 0);
        step("R4 stray", 16'h0070, 8'hCC, 1, 0, 1, 0);
        step("R4 chk", 16'h0064, 8'h00, 0, 1, 0, 0);
        // R6: local read clears only the selected channel
        step("R6 rd", 16'h0000, 8'h00, 0, 0, 0, 1);
        step("R6 chk", 16'h0064, 8'h00, 0, 1, 1, 0);
        step("R6 chk", 16'h0066, 8'h00, 0, 1, 1, 0);
        // R7: write and read of the same channel together
        step("R7 both", 16'h0062, 8'h55, 1, 0, 1, 1);
        step("R7 chk", 16'h0066, 8'h00, 0, 1, 1, 0);
        // R5: write into an emptied channel sets full again
        step("R6 rd", 16'h0000, 8'h00, 0, 0, 1, 1);
        step("R5 wr", 16'h0066, 8'h99, 1, 0, 1, 0);
        step("R5 chk", 16'h0066, 8'h00, 0, 1, 1, 0);
        // mixed traffic
        for (int n = 0; n < 3000; n++) begin
            step("mix", pick_addr(), 8'($urandom), ($urandom % 3) == 0,
                 ($urandom % 2) == 0, 1'($urandom), ($urandom % 4) == 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule